// File: doc/BRIEF.md
# Embedded Controller Host Mailbox

This block is the device side of a byte-wide host mailbox. A host reaches it through two I/O offsets. The data offset carries address, data and result bytes. The control offset returns a status byte when read and takes a command byte when written. The host writes bytes one at a time. Before each write it polls an input-full flag, and before it collects a result it waits for an output-full flag.

A small command engine turns the byte stream into accesses on a simple local register bus that reaches a 256-byte register space. A read command takes one address byte and returns the addressed byte on the data offset. A write command takes an address byte and then a data byte, and stores the data byte at that address. Two further commands set and clear a burst flag that the host can see in the status byte. A query command returns a "no event pending" code. Event delivery to the host and the contents of the register space are outside this block.

Top module: `ec_host_mailbox`

## Requirements
- R1: After reset the status byte reads 0x00, and no local bus strobe is asserted until the host writes.
- R2: Offset 0 is the data port and offset 4 is the control port. A status read at offset 4 shows output-full in bit 0, input-full in bit 1, the command flag in bit 3 and the burst flag in bit 4. All other status bits read 0. A write to any other offset is ignored.
- R3: A host write to offset 0 or 4 sets input-full, which is visible in the cycle after the write edge. The command engine consumes the byte on the next edge, so input-full reads high for exactly one cycle.
- R4: The command flag (status bit 3) is set by an accepted write to offset 4 and cleared by an accepted write to offset 0.
- R5: Command 0x80 followed by an address byte drives one local read at that address. The returned byte is presented on the data port, and output-full is set one edge after the address byte is taken.
- R6: A read of the data port clears output-full. A read of the status port leaves it set.
- R7: Command 0x81 followed by an address byte and a data byte drives exactly one local write strobe carrying that address and data.
- R8: Command 0x82 sets the burst flag and command 0x83 clears it.
- R9: Command 0x84 places 0x00 on the data port and sets output-full.
- R10: An unrecognised command byte causes no bus access and leaves the engine idle, so any data bytes that follow are dropped.
- R11: A data-port byte that arrives when no command is waiting for data causes no bus access, and it clears the command flag.
- R12: A host write that arrives while input-full is set is dropped and does not disturb the pending byte.
- R13: A command byte that arrives in the middle of a sequence abandons that sequence and starts the new command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs | input | 1 | Host access select |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_addr | input | 3 | Host offset: 0 data, 4 status/command |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Byte returned to the host, combinational |
| lb_addr | output | 8 | Local bus address |
| lb_we | output | 1 | Local bus write strobe |
| lb_re | output | 1 | Local bus read strobe |
| lb_wdata | output | 8 | Local bus write data |
| lb_rdata | input | 8 | Local bus read data, valid in the strobe cycle |

## Verification
Input-full is due in the cycle that follows the host write edge, and it is gone one edge later. The read and query results, together with output-full, also land on that second edge, which is the same edge that carries the local strobe. The bench drives every strobe at the falling edge and samples the read port just before the next rising edge. It reaches each result by polling input-full, as a host would. Each check on a flag is made at the falling edge where that count of registers puts the change.

// File: rtl/hmb_pkg.sv
package hmb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_ADDR = 2'd1,
    ST_WR_ADDR = 2'd2,
    ST_WR_DATA = 2'd3
  } hmb_state_e;

  localparam logic [7:0] CMD_READ      = 8'h80;
  localparam logic [7:0] CMD_WRITE     = 8'h81;
  localparam logic [7:0] CMD_BURST_ON  = 8'h82;
  localparam logic [7:0] CMD_BURST_OFF = 8'h83;
  localparam logic [7:0] CMD_QUERY     = 8'h84;

  localparam logic [7:0] QUERY_NONE    = 8'h00;

  localparam int STS_OBF_BIT   = 0;
  localparam int STS_IBF_BIT   = 1;
  localparam int STS_CMD_BIT   = 3;
  localparam int STS_BURST_BIT = 4;
endpackage

// File: rtl/hmb_rst_sync.sv
module hmb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/hmb_host_port.sv
module hmb_host_port
  import hmb_pkg::*;
#(
  parameter int DW       = 8,
  parameter int HAW      = 3,
  parameter int DATA_OFS = 0,
  parameter int CTRL_OFS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_cs,
  input  logic           host_wr,
  input  logic           host_rd,
  input  logic [HAW-1:0] host_addr,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  input  logic           consume,
  input  logic           result_load,
  input  logic [DW-1:0]  result_byte,
  input  logic           burst,
  output logic [DW-1:0]  in_byte,
  output logic           in_is_cmd,
  output logic           ibf,
  output logic           obf
);
  localparam logic [HAW-1:0] DATA_SEL = HAW'(DATA_OFS);
  localparam logic [HAW-1:0] CTRL_SEL = HAW'(CTRL_OFS);

  logic          sel_data, sel_ctrl;
  logic          wr_accept, rd_data;
  logic          ibf_q, ibf_d;
  logic          obf_q, obf_d;
  logic          cmd_q, cmd_d;
  logic [DW-1:0] in_q, in_d;
  logic [DW-1:0] out_q, out_d;
  logic          in_en, out_en;
  logic [DW-1:0] status;

  assign sel_data  = (host_addr == DATA_SEL);
  assign sel_ctrl  = (host_addr == CTRL_SEL);
  assign wr_accept = host_cs && host_wr && !ibf_q && (sel_data || sel_ctrl);
  assign rd_data   = host_cs && host_rd && sel_data;

  always_comb begin
    ibf_d  = ibf_q;
    obf_d  = obf_q;
    cmd_d  = cmd_q;
    in_d   = in_q;
    out_d  = out_q;
    in_en  = 1'b0;
    out_en = 1'b0;
    if (wr_accept) begin
      ibf_d = 1'b1;
      cmd_d = sel_ctrl;
      in_d  = host_wdata;
      in_en = 1'b1;
    end else if (consume) begin
      ibf_d = 1'b0;
    end
    if (result_load) begin
      obf_d  = 1'b1;
      out_d  = result_byte;
      out_en = 1'b1;
    end else if (rd_data) begin
      obf_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibf_q <= 1'b0;
      obf_q <= 1'b0;
      cmd_q <= 1'b0;
      in_q  <= '0;
      out_q <= '0;
    end else begin
      ibf_q <= ibf_d;
      obf_q <= obf_d;
      if (in_en) begin
        cmd_q <= cmd_d;
        in_q  <= in_d;
      end
      if (out_en) out_q <= out_d;
    end
  end

  always_comb begin
    status                = '0;
    status[STS_OBF_BIT]   = obf_q;
    status[STS_IBF_BIT]   = ibf_q;
    status[STS_CMD_BIT]   = cmd_q;
    status[STS_BURST_BIT] = burst;
  end

  always_comb begin
    host_rdata = '0;
    if (host_cs && host_rd) begin
      if (sel_ctrl)      host_rdata = status;
      else if (sel_data) host_rdata = out_q;
    end
  end

  assign in_byte   = in_q;
  assign in_is_cmd = cmd_q;
  assign ibf       = ibf_q;
  assign obf       = obf_q;
endmodule

// File: rtl/hmb_cmd_fsm.sv
module hmb_cmd_fsm
  import hmb_pkg::*;
#(
  parameter int DW  = 8,
  parameter int LAW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ibf,
  input  logic [DW-1:0]  in_byte,
  input  logic           in_is_cmd,
  input  logic [DW-1:0]  lb_rdata,
  output logic           consume,
  output logic           lb_re,
  output logic           lb_we,
  output logic [LAW-1:0] lb_addr,
  output logic [DW-1:0]  lb_wdata,
  output logic           result_load,
  output logic [DW-1:0]  result_byte,
  output logic           burst
);
  hmb_state_e     state_q, state_d;
  logic [LAW-1:0] addr_q, addr_d;
  logic           addr_en;
  logic           burst_q, burst_d;
  logic [7:0]     cmd_code;

  assign consume  = ibf;
  assign cmd_code = 8'(in_byte);

  always_comb begin
    state_d     = state_q;
    addr_d      = addr_q;
    addr_en     = 1'b0;
    burst_d     = burst_q;
    lb_re       = 1'b0;
    lb_we       = 1'b0;
    lb_addr     = addr_q;
    lb_wdata    = in_byte;
    result_load = 1'b0;
    result_byte = lb_rdata;
    if (ibf) begin
      if (in_is_cmd) begin
        state_d = ST_IDLE;
        unique case (cmd_code)
          CMD_READ:      state_d = ST_RD_ADDR;
          CMD_WRITE:     state_d = ST_WR_ADDR;
          CMD_BURST_ON:  burst_d = 1'b1;
          CMD_BURST_OFF: burst_d = 1'b0;
          CMD_QUERY: begin
            result_load = 1'b1;
            result_byte = DW'(QUERY_NONE);
          end
          default:       state_d = ST_IDLE;
        endcase
      end else begin
        unique case (state_q)
          ST_RD_ADDR: begin
            lb_re       = 1'b1;
            lb_addr     = in_byte[LAW-1:0];
            result_load = 1'b1;
            result_byte = lb_rdata;
            state_d     = ST_IDLE;
          end
          ST_WR_ADDR: begin
            addr_d  = in_byte[LAW-1:0];
            addr_en = 1'b1;
            state_d = ST_WR_DATA;
          end
          ST_WR_DATA: begin
            lb_we    = 1'b1;
            lb_addr  = addr_q;
            lb_wdata = in_byte;
            state_d  = ST_IDLE;
          end
          default: state_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      burst_q <= 1'b0;
    end else begin
      state_q <= state_d;
      burst_q <= burst_d;
      if (addr_en) addr_q <= addr_d;
    end
  end

  assign burst = burst_q;
endmodule

// File: rtl/ec_host_mailbox.sv
module ec_host_mailbox #(
  parameter int DW       = 8,
  parameter int HAW      = 3,
  parameter int LAW      = 8,
  parameter int DATA_OFS = 0,
  parameter int CTRL_OFS = 4,
  parameter int SYNC_STG = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_cs,
  input  logic           host_wr,
  input  logic           host_rd,
  input  logic [HAW-1:0] host_addr,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  output logic [LAW-1:0] lb_addr,
  output logic           lb_we,
  output logic           lb_re,
  output logic [DW-1:0]  lb_wdata,
  input  logic [DW-1:0]  lb_rdata
);
  logic          rst_n_sync;
  logic          consume, result_load, burst;
  logic [DW-1:0] result_byte, in_byte;
  logic          in_is_cmd, ibf, obf;

  hmb_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  hmb_host_port #(
    .DW(DW), .HAW(HAW), .DATA_OFS(DATA_OFS), .CTRL_OFS(CTRL_OFS)
  ) u_port (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .host_cs     (host_cs),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .consume     (consume),
    .result_load (result_load),
    .result_byte (result_byte),
    .burst       (burst),
    .in_byte     (in_byte),
    .in_is_cmd   (in_is_cmd),
    .ibf         (ibf),
    .obf         (obf)
  );

  hmb_cmd_fsm #(.DW(DW), .LAW(LAW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .ibf         (ibf),
    .in_byte     (in_byte),
    .in_is_cmd   (in_is_cmd),
    .lb_rdata    (lb_rdata),
    .consume     (consume),
    .lb_re       (lb_re),
    .lb_we       (lb_we),
    .lb_addr     (lb_addr),
    .lb_wdata    (lb_wdata),
    .result_load (result_load),
    .result_byte (result_byte),
    .burst       (burst)
  );
endmodule

// File: rtl/ec_host_mailbox_chk.sv
module ec_host_mailbox_chk #(
  parameter int HAW      = 3,
  parameter int DATA_OFS = 0,
  parameter int CTRL_OFS = 4
) (
  input logic           clk,
  input logic           rst_n_sync,
  input logic           host_cs,
  input logic           host_wr,
  input logic           host_rd,
  input logic [HAW-1:0] host_addr,
  input logic           ibf,
  input logic           obf,
  input logic           in_is_cmd,
  input logic           burst,
  input logic           lb_we,
  input logic           lb_re
);
  AST_CTRL_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (host_cs && host_wr && !ibf && host_addr == HAW'(CTRL_OFS)) |=> (ibf && in_is_cmd)); // R4
  AST_IBF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ibf |=> !ibf); // R3
  AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !(lb_we && lb_re)); // R7
  AST_OBF_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(obf) |-> $past(ibf)); // R5
  AST_OBF_DATA_READ: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (host_cs && host_rd && host_addr == HAW'(DATA_OFS) && !ibf) |=> !obf); // R6
  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !$past(ibf) |-> $stable(burst)); // R8
  AST_WRITE_NOT_CMD: assert property (@(posedge clk) disable iff (!rst_n_sync)
    lb_we |-> !in_is_cmd); // R11
endmodule

bind ec_host_mailbox ec_host_mailbox_chk #(
  .HAW(HAW), .DATA_OFS(DATA_OFS), .CTRL_OFS(CTRL_OFS)
) u_chk (
  .clk        (clk),
  .rst_n_sync (rst_n_sync),
  .host_cs    (host_cs),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_addr  (host_addr),
  .ibf        (ibf),
  .obf        (obf),
  .in_is_cmd  (in_is_cmd),
  .burst      (burst),
  .lb_we      (lb_we),
  .lb_re      (lb_re)
);

// File: tb/ec_host_mailbox_test.sv
module ec_host_mailbox_test;
  localparam logic [2:0] P_DATA = 3'd0;
  localparam logic [2:0] P_CTRL = 3'd4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_cs, host_wr, host_rd;
  logic [2:0] host_addr;
  logic [7:0] host_wdata, host_rdata;
  logic [7:0] lb_addr, lb_wdata, lb_rdata;
  logic       lb_we, lb_re;

  logic [7:0] mem [0:255];
  int         we_cnt = 0, re_cnt = 0;
  int         checks = 0, errors = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  ec_host_mailbox uut (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_wr(host_wr),
    .host_rd(host_rd), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .lb_addr(lb_addr), .lb_we(lb_we), .lb_re(lb_re),
    .lb_wdata(lb_wdata), .lb_rdata(lb_rdata)
  );

  assign lb_rdata = mem[lb_addr];

  always @(posedge clk) begin
    if (lb_we) begin
      mem[lb_addr] <= lb_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (lb_re) re_cnt <= re_cnt + 1;
  end

  // {is_read, address, data}: writes fill the space, reads expect the data column
  localparam logic [16:0] VECS [0:7] = '{
    17'h0_10A5, 17'h0_113C, 17'h0_FF81, 17'h0_007E,
    17'h1_10A5, 17'h1_113C, 17'h1_FF81, 17'h1_007E
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [2:0] port, input logic [7:0] val);
    host_cs = 1'b1; host_wr = 1'b1; host_addr = port; host_wdata = val;
    @(posedge clk);
    @(negedge clk);
    host_cs = 1'b0; host_wr = 1'b0;
  endtask

  task automatic hr(input logic [2:0] port, output logic [7:0] val);
    host_cs = 1'b1; host_rd = 1'b1; host_addr = port;
    #1 val = host_rdata;
    @(posedge clk);
    @(negedge clk);
    host_cs = 1'b0; host_rd = 1'b0;
  endtask

  task automatic wait_ibf_clear();
    logic [7:0] s;
    bit done = 1'b0;
    for (int i = 0; i < 500 && !done; i++) begin
      hr(P_CTRL, s);
      done = !s[1];
    end
    check(done, "R3 input-full never cleared", 0, 1);
  endtask

  task automatic wait_obf_set();
    logic [7:0] s;
    bit done = 1'b0;
    for (int i = 0; i < 500 && !done; i++) begin
      hr(P_CTRL, s);
      done = s[0];
    end
    check(done, "R5 output-full never set", 0, 1);
  endtask

  task automatic hput(input logic [2:0] port, input logic [7:0] val);
    wait_ibf_clear();
    hw(port, val);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int we0, re0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    rst_n = 1'b0; host_cs = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
    host_addr = '0; host_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    hr(P_CTRL, rv);
    check(rv == 8'h00, "R1 status after reset", rv, 8'h00);
    check(we_cnt == 0 && re_cnt == 0, "R1 no bus strobe after reset", we_cnt + re_cnt, 0);

    // vector table: writes (R7) then reads (R5, R6)
    for (int v = 0; v < 8; v++) begin
      logic [7:0] a, d;
      a = VECS[v][15:8]; d = VECS[v][7:0];
      if (!VECS[v][16]) begin
        we0 = we_cnt;
        hput(P_CTRL, 8'h81); hput(P_DATA, a); hput(P_DATA, d);
        wait_ibf_clear();
        check(we_cnt == we0 + 1, "R7 one write strobe", we_cnt - we0, 1);
        check(mem[a] == d, "R7 stored byte", mem[a], d);
      end else begin
        re0 = re_cnt;
        hput(P_CTRL, 8'h80); hput(P_DATA, a);
        wait_obf_set();
        hr(P_DATA, rv);
        check(rv == d, "R5 read result", rv, d);
        check(re_cnt == re0 + 1, "R5 one read strobe", re_cnt - re0, 1);
        hr(P_CTRL, rv);
        check(rv[0] == 1'b0, "R6 output-full cleared by data read", rv[0], 0);
      end
    end

    // R3/R4 input-full timing and command flag
    wait_ibf_clear();
    hw(P_CTRL, 8'h83);
    hr(P_CTRL, rv);
    check(rv == 8'h0A, "R3 input-full high one cycle after write", rv, 8'h0A);
    hr(P_CTRL, rv);
    check(rv == 8'h08, "R3 input-full cleared next cycle, R4 command flag", rv, 8'h08);

    // R8 burst flag
    hput(P_CTRL, 8'h82); wait_ibf_clear();
    hr(P_CTRL, rv);
    check(rv == 8'h18, "R8 burst set", rv, 8'h18);
    hput(P_CTRL, 8'h83); wait_ibf_clear();
    hr(P_CTRL, rv);
    check(rv == 8'h08, "R8 burst cleared", rv, 8'h08);

    // R9 query, R6 status read keeps output-full
    hput(P_CTRL, 8'h84);
    wait_obf_set();
    hr(P_CTRL, rv);
    check(rv == 8'h09, "R6 status read keeps output-full", rv, 8'h09);
    hr(P_DATA, rv);
    check(rv == 8'h00, "R9 query result", rv, 8'h00);

    // R11 stray data byte
    we0 = we_cnt; re0 = re_cnt;
    hput(P_DATA, 8'h55); wait_ibf_clear();
    hr(P_CTRL, rv);
    check(rv == 8'h00, "R11 stray data clears command flag", rv, 8'h00);
    check(we_cnt == we0 && re_cnt == re0, "R11 stray data no bus access", we_cnt + re_cnt, we0 + re0);

    // R10 unknown command then data
    hput(P_CTRL, 8'h99); hput(P_DATA, 8'h20); hput(P_DATA, 8'h30); wait_ibf_clear();
    hr(P_CTRL, rv);
    check(rv == 8'h00, "R10 unknown command status", rv, 8'h00);
    check(we_cnt == we0 && re_cnt == re0, "R10 unknown command no bus access", we_cnt + re_cnt, we0 + re0);

    // R2 write to an unused offset is ignored
    hput(3'd2, 8'h81);
    hr(P_CTRL, rv);
    check(rv == 8'h00, "R2 unused offset ignored", rv, 8'h00);

    // R13 command restarts a sequence
    we0 = we_cnt;
    hput(P_CTRL, 8'h81); hput(P_DATA, 8'h40);
    hput(P_CTRL, 8'h80); hput(P_DATA, 8'h10);
    wait_obf_set();
    hr(P_DATA, rv);
    check(rv == 8'hA5, "R13 restarted as read", rv, 8'hA5);
    check(we_cnt == we0 && mem[8'h40] == 8'h00, "R13 abandoned write", we_cnt - we0, 0);

    // R12 write while input-full is set is dropped
    wait_ibf_clear();
    hw(P_CTRL, 8'h80);
    hw(P_DATA, 8'h11);
    hput(P_DATA, 8'h00);
    wait_obf_set();
    hr(P_DATA, rv);
    check(rv == 8'h7E, "R12 early byte dropped", rv, 8'h7E);

    // R1 reset while a result is pending
    hput(P_CTRL, 8'h84);
    wait_obf_set();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    hr(P_CTRL, rv);
    check(rv == 8'h00, "R1 status after mid-run reset", rv, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule